// File: doc/BRIEF.md
# Handshaked Display Clock Divider

This block produces a display or pixel clock from one of three free-running input clocks. The output is the selected clock divided by an integer from 1 to 256. Software controls it through one 32-bit control/status word. A write changes the divide ratio or the source only when a change-enable bit was already set and is set again in the written word. Once a change is taken, a busy flag reads 1 until the new setting drives the output.

The input clocks pass through a glitch-free switch. Each input has its own enable. An enable drops on a falling edge of its own clock, and the next input's enable rises only after that, again on a falling edge. A stop bit holds the output low, so software can switch the source while nothing toggles downstream. A source code with no clock behind it keeps the output low.

The divider emits one high phase of the selected clock in every N cycles of that clock. For a ratio of 1 the output follows the selected clock.

Top module: `pixclk_div`

## Requirements
- R1: After reset the control word reads 0. That means divide field 0 (ratio 1), source code 0, change-enable 0, busy 0 and stop 0. The output then runs at the rate of input 0.
- R2: Word layout: source code in bits 31:30, change-enable in bit 28, busy in bit 27, stop in bit 26, divide field in bits 7:0. A write updates the source and divide fields only when the stored change-enable is 1 and bit 28 of the written word is 1. Otherwise both fields keep their values.
- R3: With divide field F (0 to 255), the output has a period of exactly F+1 cycles of the selected input.
- R4: Source code 0, 1 or 2 selects `src_clk[0]`, `src_clk[1]` or `src_clk[2]`. The code reads back as written.
- R5: Source code 3 selects no clock. The output stays low and the busy flag clears once every input enable has dropped.
- R6: Busy reads 1 in the cycle after a write is accepted. It stays 1 for at least two cycles of the selected input, until the new divide value is loaded and the switch has settled on the selected input.
- R7: A write to the divide or source field while busy reads 1 is ignored.
- R8: While stop is 1 the output is held low, at the latest a few input cycles after the stop write. Clearing stop lets the output resume at the programmed ratio.
- R9: Two input enables are never high together, and every high phase of the output lasts at least one high phase of the fastest input.
- R10: Change-enable and stop can be written at any time. Writing bit 27 has no effect, so busy cannot be forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control/status word |
| src_clk | input | 3 | Candidate input clocks, index equals source code |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
Suppose the switch enables become stuck or overlap. The busy flag then never clears, or the output shows a high phase shorter than any input's, within a few input cycles of the switch. A lost or early request toggle appears as a busy flag that clears before the period changes, or never clears. A loaded divide value that is off by one shows up as a wrong output period on the very next period measured after busy falls.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;
  // control word bit positions; software decodes these
  localparam int SEL_LSB  = 30;
  localparam int CE_POS   = 28;
  localparam int BUSY_POS = 27;
  localparam int STOP_POS = 26;

  // division ratio for a stored divide field
  function automatic int unsigned div_ratio(input int unsigned field);
    return field + 1;
  endfunction

  // expected enable pattern of the source switch for a given code
  function automatic logic [31:0] code_to_enables(input int unsigned code,
                                                  input int unsigned nsrc);
    return (code < nsrc) ? (32'd1 << code) : 32'd0;
  endfunction
endpackage

// File: rtl/pcd_sync.sv
`timescale 1ns/1ps
module pcd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter bit FALL = 1'b0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    if (FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
        end else begin
          st[0] <= d;
          for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
        end else begin
          st[0] <= d;
          for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/pcd_regs.sv
`timescale 1ns/1ps
module pcd_regs
  import pcd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2,
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [NSRC-1:0]  mux_en_s,
  input  logic             ack_s,
  output logic [31:0]      rd_data,
  output logic [DIV_W-1:0] div_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             stop_q,
  output logic             req_q,
  output logic             busy,
  output logic             accept
);
  logic        ce_q;
  logic        settled;
  logic        src_live;
  logic [31:0] want_en;
  logic        unused_bits;

  assign want_en  = code_to_enables(32'(sel_q), NSRC);
  assign settled  = (mux_en_s == want_en[NSRC-1:0]);
  assign src_live = (32'(sel_q) < NSRC);
  assign busy     = !settled || (src_live && (req_q != ack_s));
  assign accept   = wr_en && ce_q && wr_data[CE_POS] && !busy;

  assign unused_bits = ^{want_en[31:NSRC], wr_data[SEL_LSB-1], wr_data[BUSY_POS],
                         wr_data[STOP_POS-1:DIV_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      stop_q <= 1'b0;
      div_q  <= '0;
      sel_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        ce_q   <= wr_data[CE_POS];
        stop_q <= wr_data[STOP_POS];
      end
      if (accept) begin
        div_q <= wr_data[DIV_W-1:0];
        sel_q <= wr_data[SEL_LSB +: SEL_W];
        req_q <= ~req_q;
      end
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[SEL_LSB +: SEL_W]    = sel_q;
    rd_data[CE_POS]              = ce_q;
    rd_data[BUSY_POS]            = busy;
    rd_data[STOP_POS]            = stop_q;
    rd_data[DIV_W-1:0]           = div_q;
  end
endmodule

// File: rtl/pcd_srcmux.sv
`timescale 1ns/1ps
module pcd_srcmux #(
  parameter int NSRC = 3,
  parameter int SEL_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic [NSRC-1:0]  en,
  output logic             mclk
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_leg
      logic want;
      // a leg may start only once every other leg has dropped
      assign want = (32'(sel) == i) && ((en & ~(NSRC'(1) << i)) == '0);
      pcd_sync #(.W(1), .STAGES(SYNC_N), .FALL(1'b1), .RST_VAL(1'(i == 0))) u_leg_sync (
        .clk(src_clk[i]), .rst_n(rst_n), .d(want), .q(en[i]));
    end
  endgenerate

  assign mclk = |(src_clk & en);
endmodule

// File: rtl/pcd_divider.sv
`timescale 1ns/1ps
module pcd_divider #(
  parameter int DIV_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             stop,
  input  logic [DIV_W-1:0] div_q,
  output logic             ack,
  output logic             clk_out
);
  logic             req_s;
  logic             stop_s;
  logic [DIV_W-1:0] div_cur;
  logic [DIV_W-1:0] cnt;
  logic             gate;

  pcd_sync #(.W(1), .STAGES(SYNC_N)) u_req_sync (
    .clk(mclk), .rst_n(rst_n), .d(req), .q(req_s));
  pcd_sync #(.W(1), .STAGES(SYNC_N)) u_stop_sync (
    .clk(mclk), .rst_n(rst_n), .d(stop), .q(stop_s));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      div_cur <= '0;
      cnt     <= '0;
    end else begin
      ack <= req_s;
      if (req_s != ack) div_cur <= div_q;
      cnt <= (cnt >= div_cur) ? '0 : cnt + 1'b1;
    end
  end

  // enable changes only while the selected clock is low
  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= (cnt == '0) && !stop_s;
  end

  assign clk_out = mclk & gate;
endmodule

// File: rtl/pixclk_div.sv
`timescale 1ns/1ps
module pixclk_div #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2,
  parameter int NSRC = 3,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NSRC-1:0] src_clk,
  output logic            clk_out
);
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic             stop_q;
  logic             req_q;
  logic             busy;
  logic             accept;
  logic [NSRC-1:0]  mux_en;
  logic [NSRC-1:0]  mux_en_s;
  logic             mclk;
  logic             ack;
  logic             ack_s;

  pcd_regs #(.DIV_W(DIV_W), .SEL_W(SEL_W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mux_en_s(mux_en_s), .ack_s(ack_s), .rd_data(rd_data),
    .div_q(div_q), .sel_q(sel_q), .stop_q(stop_q), .req_q(req_q),
    .busy(busy), .accept(accept));

  pcd_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W), .SYNC_N(SYNC_N)) u_mux (
    .rst_n(rst_n), .src_clk(src_clk), .sel(sel_q), .en(mux_en), .mclk(mclk));

  pcd_divider #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_div (
    .mclk(mclk), .rst_n(rst_n), .req(req_q), .stop(stop_q), .div_q(div_q),
    .ack(ack), .clk_out(clk_out));

  pcd_sync #(.W(NSRC), .STAGES(SYNC_N), .RST_VAL(NSRC'(1))) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(mux_en), .q(mux_en_s));

  pcd_sync #(.W(1), .STAGES(SYNC_N)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s));
endmodule

// File: rtl/pcd_checker.sv
`timescale 1ns/1ps
module pcd_checker #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2,
  parameter int NSRC = 3,
  parameter int STOP_LAT = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             accept,
  input logic             busy,
  input logic [DIV_W-1:0] div_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             stop_q,
  input logic [NSRC-1:0]  mux_en,
  input logic             clk_out
);
  int stop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stop_cnt <= 0;
    else if (!stop_q || busy)   stop_cnt <= 0;
    else if (stop_cnt < STOP_LAT) stop_cnt <= stop_cnt + 1;
  end

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_ignored_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> ($stable(div_q) && $stable(sel_q)));

  assert_switch_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_en));

  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cnt >= STOP_LAT) |-> !clk_out);

  assert_no_source_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(sel_q) >= NSRC) && !busy) |-> !clk_out);
endmodule

bind pixclk_div pcd_checker #(.DIV_W(DIV_W), .SEL_W(SEL_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .accept(accept), .busy(busy),
  .div_q(div_q), .sel_q(sel_q), .stop_q(stop_q), .mux_en(mux_en), .clk_out(clk_out));

// File: tb/sim_pixclk_div.sv
`timescale 1ns/1ps
module sim_pixclk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
  logic [2:0]  src_clk;
  logic        clk_out;

  int errors = 0;
  int checks = 0;
  int src_rises [3];
  int out_rises = 0;
  realtime last_rise = 0;
  realtime min_high = 1000.0;
  int sel_cur = 0;
  int div_cur = 0;

  assign src_clk = {s2, s1, s0};

  pixclk_div u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                 .rd_data(rd_data), .src_clk(src_clk), .clk_out(clk_out));

  always #2 clk = ~clk;
  always #3 s0 = ~s0;
  always #5 s1 = ~s1;
  always #7 s2 = ~s2;

  initial begin
    src_rises[0] = 0; src_rises[1] = 0; src_rises[2] = 0;
  end
  always @(posedge s0) src_rises[0]++;
  always @(posedge s1) src_rises[1]++;
  always @(posedge s2) src_rises[2]++;
  always @(posedge clk_out) begin
    out_rises++;
    last_rise = $realtime;
  end
  always @(negedge clk_out) if ($realtime - last_rise < min_high) min_high = $realtime - last_rise;

  function automatic logic [31:0] mk(int sel, int ce, int stop, int dv);
    logic [31:0] w;
    w = '0;
    w[31:30] = 2'(sel);
    w[28] = 1'(ce);
    w[26] = 1'(stop);
    w[7:0] = 8'(dv);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (rd_data[27]) @(negedge clk);
  endtask

  task automatic measure(input int s, output int per);
    int a;
    @(negedge clk_out);
    @(negedge clk_out);
    a = src_rises[s];
    @(negedge clk_out);
    per = src_rises[s] - a;
  endtask

  task automatic set_div(input int f);
    wr(mk(sel_cur, 1, 0, div_cur));
    wr(mk(sel_cur, 1, 0, f));
    wait_idle();
    wr(mk(sel_cur, 0, 0, f));
    div_cur = f;
  endtask

  task automatic set_src(input int s);
    wr(mk(sel_cur, 1, 1, div_cur));
    wr(mk(s, 1, 1, div_cur));
    wait_idle();
    wr(mk(s, 0, 0, div_cur));
    sel_cur = s;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int per;
    int bcyc;
    int r0;
    #40;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset readback and ratio 1 on input 0
    check(rd_data == 32'd0, "R1 reset word", int'(rd_data), 0);
    measure(0, per);
    check(per == 1, "R1 reset period", per, 1);

    // R2 fields ignored without stored change-enable
    wr(mk(0, 0, 0, 5));
    @(negedge clk);
    check(rd_data[7:0] == 8'd0, "R2 no ce", int'(rd_data[7:0]), 0);
    wr(mk(0, 1, 0, 5));
    @(negedge clk);
    check(rd_data[7:0] == 8'd0 && !rd_data[27], "R2 ce set same write", int'(rd_data[7:0]), 0);
    // R6 busy right after accept and long enough
    wr(mk(0, 1, 0, 5));
    check(rd_data[27] == 1'b1, "R6 busy after accept", int'(rd_data[27]), 1);
    // R7 write while busy ignored
    wr(mk(2, 1, 0, 9));
    bcyc = 2;
    while (rd_data[27]) begin
      @(negedge clk);
      bcyc++;
    end
    check(bcyc * 4 >= 12, "R6 busy duration ns", bcyc * 4, 12);
    check(rd_data[7:0] == 8'd5 && rd_data[31:30] == 2'd0, "R7 busy write ignored",
          int'(rd_data[7:0]), 5);
    div_cur = 5;
    measure(0, per);
    check(per == 6, "R3 ratio 6", per, 6);
    // R10 busy bit not writable, ce clears
    wr(mk(0, 0, 0, 5) | 32'h0800_0000);
    @(negedge clk);
    check(rd_data == mk(0, 0, 0, 5), "R10 readback", int'(rd_data), int'(mk(0, 0, 0, 5)));

    // R3 sweep on input 0
    for (int f = 0; f <= 40; f++) begin
      set_div(f);
      measure(0, per);
      check(per == f + 1, "R3 sweep", per, f + 1);
    end
    set_div(127);
    measure(0, per);
    check(per == 128, "R3 ratio 128", per, 128);
    set_div(255);
    measure(0, per);
    check(per == 256, "R3 ratio 256", per, 256);

    // R4 other inputs
    for (int s = 1; s <= 2; s++) begin
      set_src(s);
      @(negedge clk);
      check(int'(rd_data[31:30]) == s, "R4 code readback", int'(rd_data[31:30]), s);
      for (int k = 0; k < 5; k++) begin
        int f;
        f = (k == 4) ? 16 : (k == 3 ? 7 : k);
        set_div(f);
        measure(s, per);
        check(per == f + 1, "R4 period on input", per, f + 1);
      end
    end

    // R8 stop holds output low, then resumes
    set_src(1);
    set_div(3);
    wr(mk(1, 0, 1, 3));
    repeat (30) @(negedge clk);
    r0 = out_rises;
    repeat (60) @(negedge clk);
    check(out_rises == r0, "R8 stopped", out_rises - r0, 0);
    wr(mk(1, 0, 0, 3));
    measure(1, per);
    check(per == 4, "R8 resume ratio", per, 4);

    // R5 no-clock code
    set_src(3);
    @(negedge clk);
    check(!rd_data[27] && rd_data[31:30] == 2'd3, "R5 busy clear", int'(rd_data[27]), 0);
    repeat (10) @(negedge clk);
    r0 = out_rises;
    repeat (60) @(negedge clk);
    check(out_rises == r0 && !clk_out, "R5 output low", out_rises - r0, 0);
    set_src(0);
    set_div(2);
    measure(0, per);
    check(per == 3, "R4 back to input 0", per, 3);

    // R9 no short high phase anywhere in the run
    check(min_high >= 2.9, "R9 min high tenths ns", int'(min_high * 10.0), 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule